// File: doc/BRIEF.md
# Shift-at-output fault remapping controller

This block drives and models a programmable NAND-plane compute array whose columns each produce one product term. The columns are grouped into sets of three lanes, and every set evaluates the same three lane programs over its own slice of wordlines. One set corresponds to one bit slice of an adder. A column that holds a cell stuck in the conducting state gives a wrong term, so the block never uses such a column. When one or more columns are flagged, the operation takes two compute cycles. In the first cycle the healthy columns evaluate and latch their terms. The output latch row then moves up by one set, one step per clock. In the second cycle the operand slice of the set below is applied to the wordlines of the next set up, and the healthy columns there recompute the terms that belong to the flagged columns.

With no fault flag set, the block evaluates every column in the cycle that accepts start and needs no shift steps. Lane programs and stuck cells are static configuration inputs. The stuck cells stand for the physical defects of the array. Fault flags and the operand are sampled when start is accepted. A fault pattern that a single set-level shift cannot repair raises a status flag.

Top module: `sato_remap_ctrl`

## Requirements
- R1: When start is accepted with all fault flags clear, done is high in the cycle right after the accepting edge and result already holds the final terms.
- R2: Logical column c = s*3 + p (set s, lane p) gives the complement of the AND of operand bits op_word[s*4 + r], taken over every r where lane_mask[p*4 + r] is 1. A lane with an empty mask gives 0.
- R3: When start is accepted with at least one fault flag set, done rises four cycles after the accepting edge: three shift steps, then the relocation cycle. Every column of a correctable pattern then reads its R2 value, even when flagged columns hold stuck cells.
- R4: A stuck cell at stuck_cells[q*4 + r] adds wordline r of column q's set to that column's NAND. An unflagged column that holds a stuck cell therefore reports the altered term.
- R5: uncorrectable is 1 after a start whose flags mark faults in two adjacent sets, or in the highest set. It is 0 after a start with any other pattern. It holds its value until the next accepted start.
- R6: A start asserted while an operation is in progress has no effect. The result and uncorrectable of the running operation are unchanged.
- R7: done stays high for exactly one cycle per operation.
- R8: Several non-adjacent faulty sets, including set 0, and several faulty lanes within one set are all repaired in a single operation.
- R9: After reset, result is all zeros and done and uncorrectable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Requests an operation; accepted only when idle |
| op_word | input | 24 | Operand bits, four wordlines per set |
| lane_mask | input | 12 | Wordline program for each of the three lanes (4 bits per lane) |
| stuck_cells | input | 72 | Array model: conducting stuck cells, 4 per column |
| fault_flags | input | 18 | One flag per column marking it unusable |
| done | output | 1 | One-cycle pulse after the final latch update |
| uncorrectable | output | 1 | Fault pattern of the last accepted start cannot be repaired |
| result | output | 18 | Logical terms held in the output latches |

## Verification
Two events can meet in the same cycle. The relocation cycle of a faulty operation, whose done is still pending, can see a new start. The done cycle itself can see a start that is accepted at once. The bench holds start high with a different operand through the whole shift and relocation phase. It also changes the fault flags to an uncorrectable pattern during that phase. It then checks that the first operation's terms and its clear status appear with done. The still-high start is accepted on the next edge, so the bench expects the second, fault-free operation to finish one cycle later with its own terms.

// File: rtl/sato_pkg.sv
package sato_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SHIFT = 2'd1,
        PH_RELOC = 2'd2
    } phase_e;
endpackage

// File: rtl/sato_term_plane.sv
// Behavioural NAND plane: each physical column NANDs the wordlines of its set
// that are either programmed for its lane or pulled in by a stuck cell.
module sato_term_plane #(
    parameter int NSETS = 6,
    parameter int LANES = 3,
    parameter int RPS   = 4
) (
    input  logic [NSETS*RPS-1:0]       wl,
    input  logic [LANES*RPS-1:0]       lane_mask,
    input  logic [NSETS*LANES*RPS-1:0] stuck_cells,
    output logic [NSETS*LANES-1:0]     term
);
    for (genvar s = 0; s < NSETS; s++) begin : g_set
        for (genvar p = 0; p < LANES; p++) begin : g_lane
            localparam int Q = s*LANES + p;
            logic [RPS-1:0] used;
            assign used    = lane_mask[p*RPS +: RPS] | stuck_cells[Q*RPS +: RPS];
            assign term[Q] = ~&(wl[s*RPS +: RPS] | ~used);
        end
    end
endmodule

// File: rtl/sato_fault_screen.sv
// Classifies a fault pattern: which sets are hit, whether one set-level shift
// can repair it, and which physical columns serve the relocated terms.
module sato_fault_screen #(
    parameter int NSETS = 6,
    parameter int LANES = 3
) (
    input  logic [NSETS*LANES-1:0] faults,
    output logic                   any_fault,
    output logic                   uncorrectable,
    output logic [NSETS*LANES-1:0] reloc_en
);
    localparam int NCOLS = NSETS*LANES;

    logic [NSETS-1:0] set_bad;
    logic [NSETS-1:0] clash;

    for (genvar s = 0; s < NSETS; s++) begin : g_set
        assign set_bad[s] = |faults[s*LANES +: LANES];
        if (s < NSETS-1) begin : g_pair
            assign clash[s] = set_bad[s] & set_bad[s+1];
        end else begin : g_top
            assign clash[s] = set_bad[s];   // no set above to borrow from
        end
    end

    assign any_fault     = |set_bad;
    assign uncorrectable = |clash;
    assign reloc_en      = {faults[NCOLS-LANES-1:0], {LANES{1'b0}}};
endmodule

// File: rtl/sato_remap_ctrl.sv
module sato_remap_ctrl
    import sato_pkg::*;
#(
    parameter int NSETS = 6,
    parameter int LANES = 3,
    parameter int RPS   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [NSETS*RPS-1:0]       op_word,
    input  logic [LANES*RPS-1:0]       lane_mask,
    input  logic [NSETS*LANES*RPS-1:0] stuck_cells,
    input  logic [NSETS*LANES-1:0]     fault_flags,
    output logic                       done,
    output logic                       uncorrectable,
    output logic [NSETS*LANES-1:0]     result
);
    localparam int NCOLS = NSETS*LANES;
    localparam int NROWS = NSETS*RPS;
    localparam int NLAT  = NCOLS + LANES;
    localparam int CW    = $clog2(LANES + 1);

    typedef struct packed {
        phase_e           ph;
        logic [CW-1:0]    cnt;
        logic [NROWS-1:0] op;
        logic [NCOLS-1:0] flt;
        logic [NLAT-1:0]  lat;
        logic             done;
        logic             unc;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [NROWS-1:0] wl;
    logic [NCOLS-1:0] flt_sel;
    logic [NCOLS-1:0] term;
    logic [NCOLS-1:0] reloc_en;
    logic             scr_any;
    logic             scr_unc;

    // Wordline multiplexer: own slice while idle, slice of the set below later.
    assign wl      = (c_q.ph == PH_IDLE) ? op_word : {c_q.op[NROWS-RPS-1:0], {RPS{1'b0}}};
    assign flt_sel = (c_q.ph == PH_IDLE) ? fault_flags : c_q.flt;

    sato_term_plane #(.NSETS(NSETS), .LANES(LANES), .RPS(RPS)) u_plane (
        .wl          (wl),
        .lane_mask   (lane_mask),
        .stuck_cells (stuck_cells),
        .term        (term)
    );

    sato_fault_screen #(.NSETS(NSETS), .LANES(LANES)) u_screen (
        .faults        (flt_sel),
        .any_fault     (scr_any),
        .uncorrectable (scr_unc),
        .reloc_en      (reloc_en)
    );

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        case (c_q.ph)
            PH_IDLE: begin
                if (start) begin
                    c_d.op  = op_word;
                    c_d.flt = fault_flags;
                    c_d.unc = scr_unc;
                    if (!scr_any) begin
                        c_d.lat[NLAT-1:LANES] = term;
                        c_d.done              = 1'b1;
                    end else begin
                        for (int c = 0; c < NCOLS; c++) begin
                            if (!fault_flags[c]) c_d.lat[c] = term[c];
                        end
                        c_d.cnt = '0;
                        c_d.ph  = PH_SHIFT;
                    end
                end
            end
            PH_SHIFT: begin
                c_d.lat = {c_q.lat[NLAT-2:0], 1'b0};
                c_d.cnt = c_q.cnt + CW'(1);
                if (c_q.cnt == CW'(LANES-1)) c_d.ph = PH_RELOC;
            end
            PH_RELOC: begin
                for (int q = 0; q < NCOLS; q++) begin
                    if (reloc_en[q]) c_d.lat[q] = term[q];
                end
                c_d.done = 1'b1;
                c_d.ph   = PH_IDLE;
            end
            default: c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{ph: PH_IDLE, cnt: '0, op: '0, flt: '0, lat: '0, done: 1'b0, unc: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign done          = c_q.done;
    assign uncorrectable = c_q.unc;
    assign result        = c_q.lat[NLAT-1:LANES];

    // R1
    ff_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.ph == PH_IDLE && start && fault_flags == '0) |=> (done && c_q.ph == PH_IDLE));

    // R3
    faulty_two_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.ph == PH_IDLE && start && fault_flags != '0) |=> (!done && c_q.ph == PH_SHIFT));

    // R3
    lat_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.ph == PH_SHIFT) |=> (c_q.lat[NLAT-1:1] == $past(c_q.lat[NLAT-2:0])));

    // R3
    reloc_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.ph == PH_RELOC) |=> (done && c_q.ph == PH_IDLE));

    // R5
    no_flagged_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.ph == PH_RELOC && !c_q.unc) |-> ((reloc_en & c_q.flt) == '0));

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.ph != PH_IDLE) |=> ($stable(uncorrectable) && $stable(c_q.op)));
endmodule

// File: tb/sato_remap_ctrl_tb.sv
`timescale 1ns/1ps
module sato_remap_ctrl_tb;
    localparam int NSETS = 6;
    localparam int LANES = 3;
    localparam int RPS   = 4;
    localparam int NCOLS = NSETS*LANES;
    localparam int NROWS = NSETS*RPS;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start = 1'b0;
    logic [NROWS-1:0]      op_word = '0;
    logic [LANES*RPS-1:0]  lane_mask = '0;
    logic [NCOLS*RPS-1:0]  stuck_cells = '0;
    logic [NCOLS-1:0]      fault_flags = '0;
    logic                  done;
    logic                  uncorrectable;
    logic [NCOLS-1:0]      result;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sato_remap_ctrl #(.NSETS(NSETS), .LANES(LANES), .RPS(RPS)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_word(op_word),
        .lane_mask(lane_mask), .stuck_cells(stuck_cells), .fault_flags(fault_flags),
        .done(done), .uncorrectable(uncorrectable), .result(result)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Array model: stuck cells act as extra always-included inputs.
    function automatic logic pterm(input int q, input int p, input logic [RPS-1:0] w);
        logic acc = 1'b1;
        for (int r = 0; r < RPS; r++)
            if (lane_mask[p*RPS + r] || stuck_cells[q*RPS + r]) acc = acc & w[r];
        return ~acc;
    endfunction

    function automatic logic [NCOLS-1:0] expect_res(input logic [NROWS-1:0] o,
                                                    input logic [NCOLS-1:0] f);
        logic [NCOLS-1:0] e;
        for (int c = 0; c < NCOLS; c++) begin
            int s = c / LANES;
            int p = c % LANES;
            int q = (f[c] && c + LANES < NCOLS) ? c + LANES : c;
            e[c] = pterm(q, p, o[s*RPS +: RPS]);
        end
        return e;
    endfunction

    function automatic logic [NCOLS*RPS-1:0] stuck_for(input logic [NCOLS-1:0] f);
        logic [NCOLS*RPS-1:0] sc = '0;
        for (int c = 0; c < NCOLS; c++)
            if (f[c]) sc[c*RPS +: RPS] = RPS'($urandom_range(1, (1 << RPS) - 1));
        return sc;
    endfunction

    task automatic run_op(input logic [NROWS-1:0] o, input logic [NCOLS-1:0] f,
                          input string req, input bit chk_res, input bit exp_unc);
        int lat = (f == '0) ? 0 : LANES + 1;
        logic [NCOLS-1:0] e = expect_res(o, f);
        @(negedge clk);
        op_word = o; fault_flags = f; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < lat; n++) begin
            chk(done == 1'b0, req, "done early", done, 0);
            @(negedge clk);
        end
        chk(done == 1'b1, req, "done at latency", done, 1);
        chk(uncorrectable == exp_unc, "R5", "uncorrectable", uncorrectable, exp_unc);
        if (chk_res) chk(result == e, req, "result", result, e);
        @(negedge clk);
        chk(done == 1'b0, "R7", "done width", done, 0);
    endtask

    task automatic t_reset();
        chk(result == '0, "R9", "reset result", result, 0);
        chk(done == 1'b0, "R9", "reset done", done, 0);
        chk(uncorrectable == 1'b0, "R9", "reset flag", uncorrectable, 0);
    endtask

    task automatic t_fault_free();
        stuck_cells = '0;
        lane_mask = 12'b0000_0110_1011;   // lane 2 empty
        run_op('1, '0, "R1", 1'b1, 1'b0);
        run_op('0, '0, "R2", 1'b1, 1'b0);
        chk(result[2] == 1'b0, "R2", "empty lane", result[2], 0);
        chk(result[0] == 1'b1, "R2", "zero operand", result[0], 1);
        lane_mask = 12'b1001_0110_1101;
        run_op(24'h5A3C96, '0, "R2", 1'b1, 1'b0);
        run_op(24'hC3E10F, '0, "R1", 1'b1, 1'b0);
    endtask

    task automatic t_stuck_unflagged();
        lane_mask = 12'b1100_0011_0101;   // lane 1 uses rows 0,1
        stuck_cells = '0;
        stuck_cells[7*RPS + 2] = 1'b1;    // column 7 = set 2, lane 1
        run_op(24'h000B00, '0, "R4", 1'b1, 1'b0);
        chk(result[7] == 1'b1, "R4", "stuck row pulled in", result[7], 1);
        stuck_cells = '0;
    endtask

    task automatic t_single_fault();
        logic [NCOLS-1:0] f;
        lane_mask = 12'b1011_0110_1110;
        f = 18'h00002;                    // set 0, lane 1
        stuck_cells = stuck_for(f);
        run_op(24'h3F5A81, f, "R3", 1'b1, 1'b0);
        f = 18'h00600;                    // set 3, lanes 0 and 1
        stuck_cells = stuck_for(f);
        run_op(24'h9E07D4, f, "R3", 1'b1, 1'b0);
        run_op(24'h000FFF, f, "R3", 1'b1, 1'b0);
        stuck_cells = '0;
    endtask

    task automatic t_multi();
        logic [NCOLS-1:0] f = 18'h02181;  // cols 0,7,8,13: sets 0,2,4
        lane_mask = 12'b0111_1101_1011;
        stuck_cells = stuck_for(f);
        run_op(24'hB4D2E1, f, "R8", 1'b1, 1'b0);
        run_op(24'h6C19F7, f, "R8", 1'b1, 1'b0);
        stuck_cells = '0;
    endtask

    task automatic t_uncorr();
        run_op(24'h123456, 18'h00050, "R5", 1'b0, 1'b1); // cols 4,6: sets 1,2
        run_op(24'h654321, 18'h10000, "R5", 1'b0, 1'b1); // col 16: top set
        run_op(24'h0F0F0F, 18'h00008, "R5", 1'b1, 1'b0); // col 3: repairable
    endtask

    // Start held high through shift and relocation, then accepted in done cycle.
    task automatic t_busy_start();
        logic [NROWS-1:0] oa = 24'hA5C3E7, ob = 24'h1E8B42;
        logic [NCOLS-1:0] fa = 18'h00020;  // col 5, set 1
        logic [NCOLS-1:0] ea, eb;
        lane_mask = 12'b1010_0111_1101;
        stuck_cells = stuck_for(fa);
        ea = expect_res(oa, fa);
        eb = expect_res(ob, '0);
        @(negedge clk);
        op_word = oa; fault_flags = fa; start = 1'b1;
        @(negedge clk);
        op_word = ob; fault_flags = 18'h30000;  // would be uncorrectable
        for (int n = 0; n < LANES + 1; n++) begin
            chk(done == 1'b0, "R6", "done while busy", done, 0);
            @(negedge clk);
        end
        chk(done == 1'b1, "R6", "first op done", done, 1);
        chk(result == ea, "R6", "first op result", result, ea);
        chk(uncorrectable == 1'b0, "R6", "flag kept", uncorrectable, 0);
        fault_flags = '0;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R1", "back-to-back done", done, 1);
        chk(result == eb, "R1", "second op result", result, eb);
        @(negedge clk);
        chk(done == 1'b0, "R7", "done width", done, 0);
        stuck_cells = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fault_free();
        t_stuck_unflagged();
        t_single_fault();
        t_multi();
        t_uncorr();
        t_busy_start();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #4000000;
        checks++;
        fails++;
        $display("FAIL R7 watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule